// File: doc/BRIEF.md
# Idle-Cycle Dirty Line Cleaner

This block sits beside a write-back data cache. It writes dirty lines back to memory in the background. A line counts as dirty from the moment a processor store lands in it. Each cycle the block checks whether the memory bus is free. A cycle is free when no other master holds the bus and the cache's demand miss logic is not asking for it. After a free cycle the cleaner takes one dirty line and copies it to memory as a short burst. If the write finishes without the line being stored to again, the line is marked clean.

Demand traffic always comes first. The cleaner never starts a burst while a demand request is waiting. A burst that has already started runs to its last beat, and only then is the demand grant given. On a quiet bus the cache ends up sending stores to memory almost as they happen, much like write-through. On a saturated bus no background writes happen, and the cache keeps plain write-back behaviour.

The choice of line rotates, so no line is left waiting for ever. A flush input lets the cleaner start even when other masters keep the bus busy. A running count of dirty lines is always visible. The cache arrays and the miss logic are outside the block; they appear only as the store, demand and burst handshake ports.

Top module: `idle_cleaner`

## Requirements
- R1: A cycle with `st_valid`=1 marks line `st_idx` dirty at the next clock edge. `dirty_cnt` always equals the number of dirty lines. A store to a line that is already dirty does not change the count. A store and a clear of the same line in the same cycle leave the line dirty.
- R2: A background burst starts (`wb_valid` rises) only at the clock edge after a cycle with `bus_busy`=0 and `dmd_req`=0, with `IDLE_HOLD`=1. While `bus_busy`=1 and `flush`=0, no burst starts and dirty lines stay dirty.
- R3: While no burst is in progress, `dmd_gnt` equals `dmd_req`. A burst never starts while `dmd_req`=1. A burst in progress continues to its last beat with `dmd_gnt`=0, and `dmd_gnt` and `wb_valid` are never both 1.
- R4: A burst lasts `BEATS` beats. `wb_beat` counts from 0 to `BEATS`-1 and moves on only in a cycle with `mem_ack`=1. `wb_last`=1 marks the final beat. `wb_idx` stays constant for the whole burst. After the final beat is acknowledged, `wb_valid` is 0 for at least one cycle.
- R5: A line is cleared at the edge where its final beat is acknowledged. If `st_valid`=1 with `st_idx` equal to the line in any cycle of the burst, including the final one, the line stays dirty.
- R6: The cleaner picks the first dirty line at or above a rotating pointer, wrapping past the top index. The pointer resets to 0 and becomes the chosen index plus one (modulo `NUM_LINES`) each time a burst starts.
- R7: While `flush`=1, bursts start whether or not `bus_busy` is set, but still never while `dmd_req`=1. Holding `flush`=1 eventually cleans every line.
- R8: A cycle with `dmd_clean_valid`=1 marks line `dmd_clean_idx` clean at the next edge. This models the demand path writing the line back itself.
- R9: Reset empties the dirty map, clears the pointer, and leaves the cleaner idle with `wb_valid`=0 and `dirty_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Processor store hit this cycle |
| st_idx | input | IDX_W | Line index written by the store |
| dmd_req | input | 1 | Demand miss logic requests the memory bus |
| dmd_clean_valid | input | 1 | Demand path has written a line back itself |
| dmd_clean_idx | input | IDX_W | Line index cleaned by the demand path |
| bus_busy | input | 1 | Another master occupies the memory bus |
| flush | input | 1 | Clean regardless of bus activity |
| mem_ack | input | 1 | Memory accepts the current burst beat |
| dmd_gnt | output | 1 | Bus granted to demand traffic |
| wb_valid | output | 1 | Background burst beat is presented |
| wb_idx | output | IDX_W | Line being written back |
| wb_beat | output | BEAT_W | Beat number within the burst |
| wb_last | output | 1 | Current beat is the final one |
| dirty_cnt | output | CNT_W | Number of dirty lines |

## Verification
A stuck or wrong bit in the dirty map shows up on `dirty_cnt` at the edge after the store or clear that touched it. If the map bit is wrong, the next idle cycle also starts a burst on the wrong line, visible on `wb_idx` one cycle later. A broken rotating pointer changes the order of `wb_idx` values once two or more lines are pending, so the bench uses a set of lines that straddles the pointer. A lost store-during-write flag appears as a count that drops one cycle after the final acknowledged beat, when it should not.

// File: rtl/idle_clean_pkg.sv
package idle_clean_pkg;

  typedef enum logic [0:0] {
    CL_IDLE  = 1'b0,
    CL_WRITE = 1'b1
  } cl_state_e;

endpackage

// File: rtl/idle_gate.sv
// Detects free bus cycles: no other master, no demand request.
// idle_ok rises on the IDLE_HOLD-th consecutive free cycle.
module idle_gate #(
  parameter int IDLE_HOLD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_busy,
  input  logic dmd_req,
  output logic idle_ok
);
  localparam int RUN_W = $clog2(IDLE_HOLD + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(IDLE_HOLD);
  localparam logic [RUN_W:0]   NEED    = (RUN_W + 1)'(IDLE_HOLD);

  logic             free_now;
  logic [RUN_W-1:0] run_q, run_d;
  logic             run_en;

  always_comb begin
    free_now = !bus_busy && !dmd_req;
    run_en   = free_now ? (run_q != RUN_MAX) : (run_q != '0);
    run_d    = free_now ? (run_q + RUN_W'(1)) : '0;
    idle_ok  = free_now && (({1'b0, run_q} + (RUN_W + 1)'(1)) >= NEED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

endmodule

// File: rtl/dirty_track.sv
// Per-line dirty bitmap with a population count.
module dirty_track #(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int CNT_W = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_valid,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic                 clr_a_valid,
  input  logic [IDX_W-1:0]     clr_a_idx,
  input  logic                 clr_b_valid,
  input  logic [IDX_W-1:0]     clr_b_idx,
  output logic [NUM_LINES-1:0] dirty,
  output logic [CNT_W-1:0]     count
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic set_hit, clr_hit, bit_en, bit_d, bit_q;

    always_comb begin
      set_hit = set_valid && (set_idx == IDX_W'(g));
      clr_hit = (clr_a_valid && (clr_a_idx == IDX_W'(g))) ||
                (clr_b_valid && (clr_b_idx == IDX_W'(g)));
      bit_en  = set_hit || clr_hit;
      bit_d   = set_hit;   // store wins over any clear in the same cycle
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign dirty[g] = bit_q;
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      count = count + CNT_W'(dirty[i]);
    end
  end

endmodule

// File: rtl/rr_pick.sv
// Rotating-priority picker: first set bit at or above ptr, wrapping.
// NUM_LINES must be a power of two so the index wraps naturally.
module rr_pick #(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] dirty,
  input  logic [IDX_W-1:0]     ptr,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);
  logic [NUM_LINES-1:0] rot;
  logic [IDX_W-1:0]     off;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      rot[i] = dirty[ptr + IDX_W'(i)];
    end
    off = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (rot[i]) off = IDX_W'(i);
    end
    any = |dirty;
    idx = ptr + off;
  end

endmodule

// File: rtl/clean_engine.sv
// Burst sequencer: starts a line write on an allowed cycle, walks the beats,
// and decides whether the line may be marked clean at the end.
module clean_engine
  import idle_clean_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int BEATS     = 4,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_dirty,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic              dmd_req,
  input  logic              idle_ok,
  input  logic              flush,
  input  logic              mem_ack,
  input  logic              st_valid,
  input  logic [IDX_W-1:0]  st_idx,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [BEAT_W-1:0] wb_beat,
  output logic              wb_last,
  output logic              clr_valid,
  output logic [IDX_W-1:0]  clr_idx,
  output logic [IDX_W-1:0]  ptr,
  output logic              dmd_gnt
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  cl_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              hit_q, hit_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic              start, at_last, done, st_same, reg_en;

  always_comb begin
    start   = (state_q == CL_IDLE) && any_dirty && !dmd_req && (idle_ok || flush);
    at_last = (beat_q == LAST_BEAT);
    done    = (state_q == CL_WRITE) && mem_ack && at_last;
    st_same = st_valid && (st_idx == idx_q);
    reg_en  = start || (state_q == CL_WRITE);

    state_d = state_q;
    idx_d   = idx_q;
    beat_d  = beat_q;
    hit_d   = hit_q;
    ptr_d   = ptr_q;

    unique case (state_q)
      CL_IDLE: begin
        if (start) begin
          state_d = CL_WRITE;
          idx_d   = pick_idx;
          beat_d  = '0;
          hit_d   = 1'b0;
          ptr_d   = pick_idx + IDX_W'(1);
        end
      end
      CL_WRITE: begin
        if (st_same) hit_d = 1'b1;
        if (mem_ack) begin
          if (at_last) state_d = CL_IDLE;
          else         beat_d  = beat_q + BEAT_W'(1);
        end
      end
      default: state_d = CL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CL_IDLE;
      idx_q   <= '0;
      beat_q  <= '0;
      hit_q   <= 1'b0;
      ptr_q   <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      beat_q  <= beat_d;
      hit_q   <= hit_d;
      ptr_q   <= ptr_d;
    end
  end

  always_comb begin
    wb_valid  = (state_q == CL_WRITE);
    wb_idx    = idx_q;
    wb_beat   = beat_q;
    wb_last   = wb_valid && at_last;
    clr_valid = done && !hit_q && !st_same;
    clr_idx   = idx_q;
    ptr       = ptr_q;
    dmd_gnt   = dmd_req && (state_q == CL_IDLE);
  end

endmodule

// File: rtl/idle_cleaner.sv
module idle_cleaner #(
  parameter int NUM_LINES = 16,
  parameter int BEATS     = 4,
  parameter int IDLE_HOLD = 1,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int CNT_W  = $clog2(NUM_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic              dmd_req,
  input  logic              dmd_clean_valid,
  input  logic [IDX_W-1:0]  dmd_clean_idx,
  input  logic              bus_busy,
  input  logic              flush,
  input  logic              mem_ack,
  output logic              dmd_gnt,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [BEAT_W-1:0] wb_beat,
  output logic              wb_last,
  output logic [CNT_W-1:0]  dirty_cnt
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_s0_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0_q   <= 1'b1;
      rst_sync_n <= rst_s0_q;
    end
  end

  logic                 idle_ok;
  logic [NUM_LINES-1:0] dirty;
  logic                 any_dirty;
  logic [IDX_W-1:0]     pick_idx, ptr;
  logic                 clr_valid;
  logic [IDX_W-1:0]     clr_idx;

  idle_gate #(.IDLE_HOLD(IDLE_HOLD)) u_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_busy (bus_busy),
    .dmd_req  (dmd_req),
    .idle_ok  (idle_ok)
  );

  dirty_track #(.NUM_LINES(NUM_LINES)) u_track (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .set_valid   (st_valid),
    .set_idx     (st_idx),
    .clr_a_valid (clr_valid),
    .clr_a_idx   (clr_idx),
    .clr_b_valid (dmd_clean_valid),
    .clr_b_idx   (dmd_clean_idx),
    .dirty       (dirty),
    .count       (dirty_cnt)
  );

  rr_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .dirty (dirty),
    .ptr   (ptr),
    .any   (any_dirty),
    .idx   (pick_idx)
  );

  clean_engine #(.NUM_LINES(NUM_LINES), .BEATS(BEATS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .any_dirty (any_dirty),
    .pick_idx  (pick_idx),
    .dmd_req   (dmd_req),
    .idle_ok   (idle_ok),
    .flush     (flush),
    .mem_ack   (mem_ack),
    .st_valid  (st_valid),
    .st_idx    (st_idx),
    .wb_valid  (wb_valid),
    .wb_idx    (wb_idx),
    .wb_beat   (wb_beat),
    .wb_last   (wb_last),
    .clr_valid (clr_valid),
    .clr_idx   (clr_idx),
    .ptr       (ptr),
    .dmd_gnt   (dmd_gnt)
  );

endmodule

// File: rtl/idle_cleaner_chk.sv
module idle_cleaner_chk #(
  parameter int NUM_LINES = 16,
  parameter int BEATS     = 4,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int CNT_W  = $clog2(NUM_LINES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              dmd_req,
  input logic              bus_busy,
  input logic              flush,
  input logic              mem_ack,
  input logic              dmd_gnt,
  input logic              wb_valid,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [BEAT_W-1:0] wb_beat,
  input logic              wb_last,
  input logic [CNT_W-1:0]  dirty_cnt
);

  a_r1_store_counts: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_valid) |-> dirty_cnt != '0);

  a_r2_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(!dmd_req && (!bus_busy || flush)));

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmd_gnt && wb_valid));

  a_r3_grant_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dmd_req && !wb_valid) |-> dmd_gnt);

  a_r3_burst_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(wb_last && mem_ack)) |=> wb_valid);

  a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> wb_beat == '0);

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !mem_ack) |=> (wb_valid && $stable(wb_beat) && $stable(wb_idx)));

  a_r4_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && mem_ack && !wb_last) |=>
      (wb_beat == BEAT_W'($past(wb_beat) + 1'b1)) && $stable(wb_idx));

  a_r4_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_last && mem_ack) |=> !wb_valid);

endmodule

bind idle_cleaner idle_cleaner_chk #(.NUM_LINES(NUM_LINES), .BEATS(BEATS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .st_valid  (st_valid),
  .dmd_req   (dmd_req),
  .bus_busy  (bus_busy),
  .flush     (flush),
  .mem_ack   (mem_ack),
  .dmd_gnt   (dmd_gnt),
  .wb_valid  (wb_valid),
  .wb_idx    (wb_idx),
  .wb_beat   (wb_beat),
  .wb_last   (wb_last),
  .dirty_cnt (dirty_cnt)
);

// File: tb/idle_cleaner_test.sv
module idle_cleaner_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_LINES  = 16;
  localparam int BEATS      = 4;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st_valid = 1'b0;
  logic [3:0] st_idx = '0;
  logic       dmd_req = 1'b0;
  logic       dmd_clean_valid = 1'b0;
  logic [3:0] dmd_clean_idx = '0;
  logic       bus_busy = 1'b0;
  logic       flush = 1'b0;
  logic       mem_ack = 1'b0;
  logic       dmd_gnt, wb_valid, wb_last;
  logic [3:0] wb_idx;
  logic [1:0] wb_beat;
  logic [4:0] dirty_cnt;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  idle_cleaner #(.NUM_LINES(NUM_LINES), .BEATS(BEATS), .IDLE_HOLD(1)) uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_idx(st_idx),
    .dmd_req(dmd_req), .dmd_clean_valid(dmd_clean_valid),
    .dmd_clean_idx(dmd_clean_idx), .bus_busy(bus_busy), .flush(flush),
    .mem_ack(mem_ack), .dmd_gnt(dmd_gnt), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_beat(wb_beat), .wb_last(wb_last),
    .dirty_cnt(dirty_cnt)
  );

  // Row: st_v, st_idx, busy, dmd, flush, ack | exp wb_valid, wb_idx, cnt, gnt
  // Expected values are the outputs in the cycle the row is applied.
  localparam int NV = 22;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1,4'd3,1'b1,1'b0,1'b0,1'b0, 1'b0,4'd0,5'd0,1'b0}, // R1 store 3 under busy
    {1'b1,4'd5,1'b1,1'b0,1'b0,1'b0, 1'b0,4'd0,5'd1,1'b0}, // R1 store 5
    {1'b0,4'd0,1'b1,1'b0,1'b0,1'b0, 1'b0,4'd0,5'd2,1'b0}, // R2 busy: no start
    {1'b0,4'd0,1'b0,1'b1,1'b0,1'b0, 1'b0,4'd0,5'd2,1'b1}, // R3 demand wins
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,4'd0,5'd2,1'b0}, // R2 free cycle
    {1'b0,4'd0,1'b0,1'b1,1'b0,1'b1, 1'b1,4'd3,5'd2,1'b0}, // R6 line 3, R3 no gnt
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd3,5'd2,1'b0},
    {1'b1,4'd3,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd3,5'd2,1'b0}, // R5 store during write
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd3,5'd2,1'b0}, // last beat
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,4'd0,5'd2,1'b0}, // R5 line 3 still dirty
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd5,5'd2,1'b0}, // R6 pointer past 3 -> 5
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd5,5'd2,1'b0},
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd5,5'd2,1'b0},
    {1'b0,4'd0,1'b1,1'b0,1'b0,1'b1, 1'b1,4'd5,5'd2,1'b0}, // last beat
    {1'b0,4'd0,1'b1,1'b0,1'b0,1'b0, 1'b0,4'd0,5'd1,1'b0}, // R5 line 5 cleaned
    {1'b0,4'd0,1'b1,1'b0,1'b1,1'b0, 1'b0,4'd0,5'd1,1'b0}, // R7 flush with busy
    {1'b0,4'd0,1'b1,1'b0,1'b0,1'b0, 1'b1,4'd3,5'd1,1'b0}, // R6 wrap to 3, R4 stall
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd3,5'd1,1'b0},
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd3,5'd1,1'b0},
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd3,5'd1,1'b0},
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,4'd3,5'd1,1'b0},
    {1'b0,4'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,4'd0,5'd0,1'b0}  // R5 all clean
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  // Waits for a burst, checks its line, acknowledges every beat (R4).
  task automatic collect(input int exp_idx, input string req);
    int waited = 0;
    while (wb_valid !== 1'b1 && waited < 20) begin
      step();
      waited++;
    end
    chk(wb_valid === 1'b1, req, int'(wb_valid), 1);
    chk(int'(wb_idx) == exp_idx, req, int'(wb_idx), exp_idx);
    for (int b = 0; b < BEATS; b++) begin
      chk(int'(wb_beat) == b, "R4 beat", int'(wb_beat), b);
      chk(wb_last == (b == BEATS - 1), "R4 last", int'(wb_last), int'(b == BEATS - 1));
      mem_ack = 1'b1;
      step();
    end
    mem_ack = 1'b0;
    chk(wb_valid == 1'b0, "R4 gap", int'(wb_valid), 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk(wb_valid == 1'b0, "R9 wb_valid", int'(wb_valid), 0);
    chk(dirty_cnt == 5'd0, "R9 dirty_cnt", int'(dirty_cnt), 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      @(negedge clk);
      st_valid = v[19]; st_idx = v[18:15]; bus_busy = v[14];
      dmd_req = v[13]; flush = v[12]; mem_ack = v[11];
      #1;
      chk(wb_valid == v[10], $sformatf("row %0d R2/R3 wb_valid", i), int'(wb_valid), int'(v[10]));
      if (v[10]) chk(wb_idx == v[9:6], $sformatf("row %0d R6 wb_idx", i), int'(wb_idx), int'(v[9:6]));
      chk(dirty_cnt == v[5:1], $sformatf("row %0d R1/R5 dirty_cnt", i), int'(dirty_cnt), int'(v[5:1]));
      chk(dmd_gnt == v[0], $sformatf("row %0d R3 dmd_gnt", i), int'(dmd_gnt), int'(v[0]));
    end
    st_valid = 1'b0; bus_busy = 1'b0; dmd_req = 1'b0; flush = 1'b0; mem_ack = 1'b0;

    // R9 reset clears pending lines
    bus_busy = 1'b1; st_valid = 1'b1; st_idx = 4'd4; step(); st_valid = 1'b0;
    chk(dirty_cnt == 5'd1, "R1 store before reset", int'(dirty_cnt), 1);
    do_reset();
    chk(dirty_cnt == 5'd0, "R9 reset clears map", int'(dirty_cnt), 0);
    dmd_req = 1'b1; #1;
    chk(dmd_gnt == 1'b1, "R3 gnt after reset", int'(dmd_gnt), 1);
    dmd_req = 1'b0;

    // R6 rotation: clean 2 (pointer -> 3), then 1 and 9 go 9 first
    st_valid = 1'b1; st_idx = 4'd2; step(); st_valid = 1'b0; bus_busy = 1'b0;
    collect(2, "R6 first pick");
    bus_busy = 1'b1;
    st_valid = 1'b1; st_idx = 4'd1; step();
    st_idx = 4'd9; step(); st_valid = 1'b0;
    chk(dirty_cnt == 5'd2, "R2 held while busy", int'(dirty_cnt), 2);
    bus_busy = 1'b0;
    collect(9, "R6 rotate above pointer");
    collect(1, "R6 wrap below pointer");
    chk(dirty_cnt == 5'd0, "R5 all cleaned", int'(dirty_cnt), 0);

    // R1/R8 full map, duplicates, clears
    bus_busy = 1'b1;
    for (int l = 0; l < NUM_LINES; l++) begin
      st_valid = 1'b1; st_idx = 4'(l); step();
    end
    st_valid = 1'b0;
    chk(dirty_cnt == 5'd16, "R1 all lines dirty", int'(dirty_cnt), 16);
    st_valid = 1'b1; st_idx = 4'd0; step(); st_valid = 1'b0;
    chk(dirty_cnt == 5'd16, "R1 duplicate store", int'(dirty_cnt), 16);
    dmd_clean_valid = 1'b1; dmd_clean_idx = 4'd7; step(); dmd_clean_valid = 1'b0;
    chk(dirty_cnt == 5'd15, "R8 demand clean", int'(dirty_cnt), 15);
    st_valid = 1'b1; st_idx = 4'd7; dmd_clean_valid = 1'b1; dmd_clean_idx = 4'd7; step();
    st_valid = 1'b0; dmd_clean_valid = 1'b0;
    chk(dirty_cnt == 5'd16, "R1 store beats clear", int'(dirty_cnt), 16);

    // R7 flush still yields to demand
    flush = 1'b1; dmd_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(wb_valid == 1'b0, "R7 flush waits for demand", int'(wb_valid), 0);
      chk(dmd_gnt == 1'b1, "R3 demand granted", int'(dmd_gnt), 1);
    end
    dmd_req = 1'b0; mem_ack = 1'b1;
    repeat (120) step();
    chk(dirty_cnt == 5'd0, "R7 flush cleans all under busy", int'(dirty_cnt), 0);
    chk(wb_valid == 1'b0, "R7 idle after flush", int'(wb_valid), 0);
    flush = 1'b0; mem_ack = 1'b0; bus_busy = 1'b0;

    summary();
    $finish;
  end

endmodule